// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a reversible binary counter, four bits wide by default. It has no direction bit. It has two count inputs instead. A rising edge on the up input adds one while the down input rests high. A rising edge on the down input subtracts one while the up input rests high. Both count inputs are sampled by a free-running system clock, passed through a synchronizer and edge-detected. Every bit of the count therefore changes on the same system clock edge.

Two controls act without waiting for the clock. An active-high clear forces the count to zero and wins over everything else. An active-low preset copies the parallel data word into the count and blocks counting while it is held.

There are two active-low terminal outputs, both combinational. The carry output is low while the count is all ones and the up input is low. The borrow output is low while the count is zero and the down input is low. To build a wider counter, wire carry to the up input of the next stage and borrow to its down input. No glue logic is needed, and the stages count on the same system clock edge.

Top module: `updown_dual_counter`

## Requirements
- R1: A rising edge on `up_pulse` while `dn_pulse` is high increments `q` by one.
- R2: A rising edge on `dn_pulse` while `up_pulse` is high decrements `q` by one.
- R3: A rising edge on one count input while the other count input is low leaves `q` unchanged.
- R4: If both count inputs rise in the same system clock sample, `q` is unchanged.
- R5: Counting wraps from all ones to zero when going up, and from zero to all ones when going down.
- R6: While `load_n` is low, `q` equals `preset`. `q` takes this value as soon as `load_n` falls, without waiting for a clock edge, and count edges have no effect.
- R7: While `clr` is high, `q` is zero at once. This holds even while `load_n` is low.
- R8: `carry_n` is 0 exactly when `q` is all ones and `up_pulse` is 0; otherwise it is 1.
- R9: `borrow_n` is 0 exactly when `q` is zero and `dn_pulse` is 0; otherwise it is 1.
- R10: A count input edge that arrives between clock edges changes `q` on the third rising `clk` edge after it.
- R11: Two instances, with `carry_n` wired to the next `up_pulse` and `borrow_n` wired to the next `dn_pulse`, count as one counter of twice the width in both directions, including wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| load_n | input | 1 | Asynchronous parallel preset, active low |
| preset | input | WIDTH | Value copied into the count while `load_n` is low |
| up_pulse | input | 1 | Count-up input; its rising edge counts |
| dn_pulse | input | 1 | Count-down input; its rising edge counts |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry: count all ones and `up_pulse` low |
| borrow_n | output | 1 | Active-low borrow: count zero and `dn_pulse` low |

## Verification
A count edge on an input is due in `q` three `clk` rising edges after the bench changes that input: two synchronizer flops, then the edge register. The bench changes inputs on falling edges and reads `q` on later falling edges. It reads at least four edges after a pulse, and in the latency test it reads after the first, second and third edge.

Carry, borrow, preset and clear act with no clock in the path. The bench reads them one nanosecond after it drives them, before the next rising edge. A rising edge would otherwise let a count or a reload hide the asynchronous behaviour.

In the cascade, the carry or borrow rises at the same moment as the low stage's input. Both stages are therefore due on the same edge, and the bench checks the combined value against an integer taken modulo 256.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Decide the count action from the edges and levels of both count inputs.
  function automatic step_e decode_step(input logic up_rise, input logic dn_rise,
                                        input logic up_lvl,  input logic dn_lvl);
    step_e s;
    if (up_rise && dn_rise)      s = STEP_HOLD;
    else if (up_rise && dn_lvl)  s = STEP_UP;
    else if (dn_rise && up_lvl)  s = STEP_DOWN;
    else                         s = STEP_HOLD;
    return s;
  endfunction

  // Next count modulo 2**width; down is done by adding the all-ones mask.
  function automatic int unsigned next_count(input int unsigned cur, input step_e s,
                                             input int unsigned width);
    int unsigned mask;
    int unsigned res;
    mask = (32'd1 << width) - 32'd1;
    case (s)
      STEP_UP:   res = (cur + 32'd1) & mask;
      STEP_DOWN: res = (cur + mask) & mask;
      default:   res = cur & mask;
    endcase
    return res;
  endfunction

  // True when the count sits at the terminal value for the chosen direction.
  function automatic logic at_terminal(input int unsigned cur, input int unsigned width,
                                       input logic going_up);
    int unsigned mask;
    mask = (32'd1 << width) - 32'd1;
    return going_up ? ((cur & mask) == mask) : ((cur & mask) == 32'd0);
  endfunction

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = async_i;
    end else begin : g_next
      assign d_in = chain[g-1];
    end
    // Idle level of a count input is high.
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain[g] <= 1'b1;
      else     chain[g] <= d_in;
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/udc_edge.sv
module udc_edge (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          lvl_i,   // [0] up, [1] down, synchronized
  output logic [1:0]          rise_o,
  output udc_pkg::step_e      step_o
);
  import udc_pkg::*;

  logic [1:0] prev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev <= 2'b11;
    else     prev <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev;
  assign step_o = decode_step(rise_o[0], rise_o[1], lvl_i[0], lvl_i[1]);

  // R1 / R3: an up step needs a low-to-high up input and a high down input
  a_r1_up_step_cause: assert property (@(posedge clk) disable iff (rst)
    (step_o == STEP_UP) |-> (lvl_i[0] && !$past(lvl_i[0]) && lvl_i[1]));
  // R2 / R3: a down step needs a low-to-high down input and a high up input
  a_r2_dn_step_cause: assert property (@(posedge clk) disable iff (rst)
    (step_o == STEP_DOWN) |-> (lvl_i[1] && !$past(lvl_i[1]) && lvl_i[0]));
  // R4: a step never occurs in a sample where the other input also rose
  a_r4_no_step_on_double: assert property (@(posedge clk) disable iff (rst)
    (step_o != STEP_HOLD) |-> !(lvl_i[0] && !$past(lvl_i[0]) && lvl_i[1] && !$past(lvl_i[1])));
endmodule

// File: rtl/udc_core.sv
module udc_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic               clk,
  input  logic               clr_i,
  input  logic               load_n_i,
  input  logic [WIDTH-1:0]   preset_i,
  input  udc_pkg::step_e     step_i,
  output logic [WIDTH-1:0]   q_o
);
  import udc_pkg::*;

  always_ff @(posedge clk or posedge clr_i or negedge load_n_i) begin
    if (clr_i)          q_o <= '0;
    else if (!load_n_i) q_o <= preset_i;
    else                q_o <= WIDTH'(next_count(32'(q_o), step_i, WIDTH));
  end

  // R1 / R5: an up step adds one, wrapping
  a_r1_increment: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
    (step_i == STEP_UP) |=> (q_o == $past(q_o) + WIDTH'(1)));
  // R2 / R5: a down step subtracts one, wrapping
  a_r2_decrement: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
    (step_i == STEP_DOWN) |=> (q_o == $past(q_o) - WIDTH'(1)));
  // R3: no step, no change
  a_r3_hold_no_step: assert property (@(posedge clk) disable iff (clr_i || !load_n_i)
    (step_i == STEP_HOLD) |=> $stable(q_o));
  // R6: held preset dominates counting
  a_r6_preset_held: assert property (@(posedge clk) disable iff (clr_i)
    (!load_n_i) |=> (q_o == $past(preset_i)));
endmodule

// File: rtl/udc_term.sv
module udc_term #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  import udc_pkg::*;

  assign carry_n_o  = ~(at_terminal(32'(q_i), WIDTH, 1'b1) & ~up_lvl_i);
  assign borrow_n_o = ~(at_terminal(32'(q_i), WIDTH, 1'b0) & ~dn_lvl_i);

  // R8: carry pulse only at all ones with the up input low
  a_r8_carry_only_at_max: assert property (@(posedge clk) disable iff (rst)
    (!carry_n_o) |-> ((&q_i) && !up_lvl_i));
  // R9: borrow pulse only at zero with the down input low
  a_r9_borrow_only_at_zero: assert property (@(posedge clk) disable iff (rst)
    (!borrow_n_o) |-> ((q_i == '0) && !dn_lvl_i));
  // R8 / R9: both terminals cannot be active at once for a multi-bit count
  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!carry_n_o && !borrow_n_o));
endmodule

// File: rtl/updown_dual_counter.sv
module updown_dual_counter #(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_pulse,
  input  logic             dn_pulse,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  import udc_pkg::*;

  localparam int unsigned LANES = 2;

  logic [LANES-1:0] raw_lvl;
  logic [LANES-1:0] sync_lvl;
  logic [LANES-1:0] rise;
  step_e            step;

  assign raw_lvl = {dn_pulse, up_pulse};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    udc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (clr),
      .async_i (raw_lvl[l]),
      .sync_o  (sync_lvl[l])
    );
  end

  udc_edge u_edge (
    .clk    (clk),
    .rst    (clr),
    .lvl_i  (sync_lvl),
    .rise_o (rise),
    .step_o (step)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .clr_i    (clr),
    .load_n_i (load_n),
    .preset_i (preset),
    .step_i   (step),
    .q_o      (q)
  );

  // Terminal outputs use the raw input level so a following stage sees its
  // edge at the same instant as this stage.
  udc_term #(.WIDTH(WIDTH)) u_term (
    .clk        (clk),
    .rst        (clr),
    .q_i        (q),
    .up_lvl_i   (up_pulse),
    .dn_lvl_i   (dn_pulse),
    .carry_n_o  (carry_n),
    .borrow_n_o (borrow_n)
  );

  // R7: clear holds the count at zero
  a_r7_clear_zero: assert property (@(posedge clk) clr |-> (q == '0));
  // R4: detected edges never yield a step when both rose
  a_r4_double_rise_hold: assert property (@(posedge clk) disable iff (clr)
    (&rise) |-> (step == STEP_HOLD));
endmodule

// File: tb/tb_updown_dual_counter.sv
module tb_updown_dual_counter;
  logic       clk = 1'b0;
  logic       clr;
  logic       load_n;
  logic [7:0] preset8;
  logic       up, dn;
  logic [3:0] q_lo, q_hi;
  logic       carry_lo, borrow_lo, carry_hi, borrow_hi;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  int         model;

  always #2 clk = ~clk;   // 250 MHz

  updown_dual_counter dut (
    .clk(clk), .clr(clr), .load_n(load_n), .preset(preset8[3:0]),
    .up_pulse(up), .dn_pulse(dn), .q(q_lo), .carry_n(carry_lo), .borrow_n(borrow_lo));

  updown_dual_counter dut_hi (
    .clk(clk), .clr(clr), .load_n(load_n), .preset(preset8[7:4]),
    .up_pulse(carry_lo), .dn_pulse(borrow_lo), .q(q_hi), .carry_n(carry_hi), .borrow_n(borrow_hi));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int both();
    return int'({q_hi, q_lo});
  endfunction

  task automatic pulse_up();
    @(negedge clk) up = 1'b0;
    repeat (3) @(negedge clk);
    up = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_dn();
    @(negedge clk) dn = 1'b0;
    repeat (3) @(negedge clk);
    dn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load8(input int v);
    @(negedge clk);
    preset8 = 8'(v);
    load_n  = 1'b0;
    @(negedge clk) load_n = 1'b1;
    repeat (2) @(negedge clk);
    model = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr = 1'b1; load_n = 1'b1; preset8 = 8'h00; up = 1'b1; dn = 1'b1; model = 0;
    repeat (4) @(negedge clk);
    chk("R7 reset count", both(), 0);
    chk("R8 reset carry", int'(carry_lo), 1);
    chk("R9 reset borrow", int'(borrow_lo), 1);
    clr = 1'b0;
    repeat (3) @(negedge clk);

    // R10: latency of a count edge
    up = 1'b0;
    repeat (3) @(negedge clk);
    up = 1'b1;
    @(negedge clk) chk("R10 after 1st edge", int'(q_lo), 0);
    @(negedge clk) chk("R10 after 2nd edge", int'(q_lo), 0);
    @(negedge clk) chk("R10 after 3rd edge", int'(q_lo), 1);
    repeat (2) @(negedge clk);
    model = 1;

    // R1 / R5 / R11: full upward sweep of the cascade
    for (int k = 0; k < 256; k++) begin
      pulse_up();
      model = (model + 1) % 256;
      chk("R1 low stage up", int'(q_lo), model % 16);
      chk("R11 cascade up", both(), model);
    end

    // R2 / R5 / R11: full downward sweep including wrap below zero
    load8(0);
    for (int k = 0; k < 256; k++) begin
      pulse_dn();
      model = (model + 255) % 256;
      chk("R2 low stage down", int'(q_lo), model % 16);
      chk("R11 cascade down", both(), model);
    end

    // R5: explicit wraps
    load8(8'hFF);
    pulse_up();
    chk("R5 wrap up", both(), 0);
    pulse_dn();
    chk("R5 wrap down", both(), 255);

    // R8: carry output level
    load8(8'h0F);
    @(negedge clk) up = 1'b0;
    #1 chk("R8 carry low at max", int'(carry_lo), 0);
    @(negedge clk) up = 1'b1;
    #1 chk("R8 carry high with up high", int'(carry_lo), 1);
    repeat (4) @(negedge clk);
    chk("R11 carry into upper", both(), 8'h10);
    load8(8'h0E);
    @(negedge clk) up = 1'b0;
    #1 chk("R8 carry high below max", int'(carry_lo), 1);
    @(negedge clk) up = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 count to max", both(), 8'h0F);

    // R9: borrow output level
    load8(8'h10);
    #1 chk("R9 borrow high with down high", int'(borrow_lo), 1);
    @(negedge clk) dn = 1'b0;
    #1 chk("R9 borrow low at zero", int'(borrow_lo), 0);
    @(negedge clk) dn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 borrow from upper", both(), 8'h0F);

    // R3: up edge with down low is ignored; restoring down then counts down
    load8(8'h25);
    @(negedge clk) dn = 1'b0;
    repeat (3) @(negedge clk);
    pulse_up();
    chk("R3 up ignored while down low", both(), 8'h25);
    dn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 down rise counts", both(), 8'h24);
    @(negedge clk) up = 1'b0;
    repeat (3) @(negedge clk);
    pulse_dn();
    chk("R3 down ignored while up low", both(), 8'h24);
    up = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 up rise counts", both(), 8'h25);

    // R4: simultaneous rises hold
    @(negedge clk) begin up = 1'b0; dn = 1'b0; end
    repeat (3) @(negedge clk);
    up = 1'b1; dn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 both rise hold", both(), 8'h25);

    // R6: asynchronous preset, counting blocked while held
    @(negedge clk);
    preset8 = 8'h33;
    load_n  = 1'b0;
    #1 chk("R6 preset without clock", both(), 8'h33);
    pulse_up();
    chk("R6 count blocked by preset", both(), 8'h33);
    @(negedge clk) load_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 value kept after release", both(), 8'h33);

    // R7: clear overrides a held preset
    @(negedge clk);
    preset8 = 8'hAA;
    load_n  = 1'b0;
    #1 chk("R6 preset AA", both(), 8'hAA);
    @(negedge clk) clr = 1'b1;
    #1 chk("R7 clear beats preset", both(), 0);
    @(negedge clk) clr = 1'b0;
    @(negedge clk) chk("R6 preset after clear release", both(), 8'hAA);
    load_n = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk) clr = 1'b1;
    #1 chk("R7 clear from nonzero", both(), 0);
    @(negedge clk) clr = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule